// File: doc/BRIEF.md
# Tearing-Synchronised Frame Transfer Controller

This block sequences a single frame transfer toward a command-mode panel on a parallel bus. Software programs how many pixels the frame holds, picks how the frame should be released and then sets an enable bit. The release happens either straight away or once the panel's tearing-effect signals show that the scan has reached a safe point. That point is either the start of a refresh (a qualified vsync) or a chosen scan line (a qualified vsync followed by a count of qualified hsync pulses).

Once released, the controller asks a downstream bus engine for pixels through a request/acknowledge handshake. It counts the accepted pixels and, after the last one, pulses a frame-done interrupt for one cycle and clears its own enable bit. Each tearing input passes through a filter that rejects glitches: a pulse counts only if it holds its active level for a programmed number of clock cycles. The active level of each input is selectable.

Register map (3-bit word address, 32-bit data): 0 control (bit 0 enable, bit 4 immediate start), 1 pixel count, 2 tearing line, 3 hsync minimum width, 4 vsync minimum width, 5 config (bits 3:2 sync mode, bit 20 vsync polarity, bit 21 hsync polarity). Unmapped addresses read as zero.

Top module: `tear_sync_xfer`

## Requirements
- R1: After synchronous reset the control register reads 0, the config register reads 32'h0030_0000 (both polarity bits 1, mode 0), pix_req is low and frame_done is low.
- R2: Writing control with bit 0 = 1 and bit 4 = 1 raises pix_req on the next cycle. Exactly as many handshakes (pix_req and pix_ack high at one clock edge) complete as the pixel count held at the moment of that write.
- R3: pix_req stays high until it is acknowledged, and the remaining count falls only on a completed handshake.
- R4: frame_done is high for exactly one cycle, in the cycle right after the edge of the last handshake. From then on, control bit 0 reads 0 while bit 4 keeps its value.
- R5: A transfer started with a pixel count of 0 raises no pix_req and pulses frame_done one cycle after the transfer is released.
- R6: With bit 4 = 0, the transfer waits for the sync condition. In mode 1 (config bits 3:2 = 01) a qualified vsync releases it. In mode 0 or 3 nothing releases it.
- R7: A tearing pulse is qualified only if its active level lasts at least the programmed width in clock cycles. Shorter pulses have no effect. A width of 0 acts as 1.
- R8: Config bit 20 (vsync) and bit 21 (hsync) select the active level: 1 means active high and 0 means active low.
- R9: In mode 2 (config bits 3:2 = 10), a qualified vsync clears a line counter and each later qualified hsync increments it. The transfer is released when the counter equals the programmed line. Line 0 releases on the vsync itself. Hsync pulses before the first vsync are ignored.
- R10: A write to the line register is ignored if the value exceeds 2047. Values from 0 to 2047 are stored.
- R11: Writing control bit 0 = 0 while a transfer is waiting or running drops pix_req on the next cycle and produces no frame_done.
- R12: If a control write setting bit 0 lands on the same edge as the last handshake, the frame still ends normally (frame_done, enable cleared) and no new transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| te_hsync | input | 1 | Tearing-effect hsync from panel |
| te_vsync | input | 1 | Tearing-effect vsync from panel |
| pix_req | output | 1 | Pixel request toward bus engine |
| pix_ack | input | 1 | Pixel accepted by bus engine |
| frame_done | output | 1 | One-cycle frame-complete interrupt |

## Verification
The self-clearing of the enable bit at the end of a frame can fall on the same edge as a software write to the control register. The bench provokes this by presenting the final acknowledge and a control write with bit 0 set in the same cycle. It then judges the outcome: frame_done must pulse, the enable bit must read 0 with the immediate bit updated, and pix_req must stay low afterwards. A second collision, a qualified vsync and hsync on the same edge in line mode, resolves in favour of the vsync restarting the count.

// File: rtl/tsx_pkg.sv
`timescale 1ns/1ps
package tsx_pkg;

    localparam int REG_ADDR_W = 3;
    localparam int LINE_W     = 11;

    typedef enum logic [REG_ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_PIXCNT = 3'd1,
        A_LINE   = 3'd2,
        A_HWID   = 3'd3,
        A_VWID   = 3'd4,
        A_CFG    = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        TE_OFF   = 2'd0,
        TE_VSYNC = 2'd1,
        TE_LINE  = 2'd2,
        TE_RSVD  = 2'd3
    } te_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_RUN  = 2'd2
    } seq_state_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_IMM_BIT = 4;
    localparam int CFG_MODE_LO  = 2;
    localparam int CFG_VPOL_BIT = 20;
    localparam int CFG_HPOL_BIT = 21;

    typedef struct packed {
        te_mode_e mode;
        logic     vpol;
        logic     hpol;
    } te_cfg_t;

    // Index of each tearing channel in the qualifier array
    localparam int CH_H = 0;
    localparam int CH_V = 1;
    localparam int N_CH = 2;

    function automatic logic level_active(input logic sig, input logic pol);
        return pol ? sig : !sig;
    endfunction

endpackage

// File: rtl/tsx_regs.sv
`timescale 1ns/1ps
module tsx_regs
    import tsx_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int WID_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [31:0]           wdata,
    input  logic                  frame_end,
    output logic [31:0]           rdata,
    output logic                  en,
    output logic                  start,
    output logic                  start_imm,
    output logic                  abort,
    output logic [PIX_W-1:0]      pixcnt,
    output logic [LINE_W-1:0]     line,
    output logic [WID_W-1:0]      hwid,
    output logic [WID_W-1:0]      vwid,
    output te_cfg_t               cfg
);
    localparam int PIX_PAD  = 32 - PIX_W;
    localparam int WID_PAD  = 32 - WID_W;
    localparam int LINE_PAD = 32 - LINE_W;

    logic en_q, imm_q;
    logic wr_ctrl;

    assign wr_ctrl   = wr && (reg_addr_e'(addr) == A_CTRL);
    assign start     = wr_ctrl && wdata[CTRL_EN_BIT] && !en_q && !frame_end;
    assign start_imm = wdata[CTRL_IMM_BIT];
    assign abort     = wr_ctrl && !wdata[CTRL_EN_BIT];
    assign en        = en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            imm_q  <= 1'b0;
            pixcnt <= '0;
            line   <= '0;
            hwid   <= '0;
            vwid   <= '0;
            cfg    <= '{mode: TE_OFF, vpol: 1'b1, hpol: 1'b1};
        end else begin
            if (frame_end)
                en_q <= 1'b0;
            else if (wr_ctrl)
                en_q <= wdata[CTRL_EN_BIT];
            if (wr_ctrl)
                imm_q <= wdata[CTRL_IMM_BIT];
            if (wr) begin
                case (reg_addr_e'(addr))
                    A_PIXCNT: pixcnt <= wdata[PIX_W-1:0];
                    A_LINE: begin
                        if (wdata[31:LINE_W] == '0)
                            line <= wdata[LINE_W-1:0];
                    end
                    A_HWID: hwid <= wdata[WID_W-1:0];
                    A_VWID: vwid <= wdata[WID_W-1:0];
                    A_CFG: begin
                        cfg.mode <= te_mode_e'(wdata[CFG_MODE_LO+1:CFG_MODE_LO]);
                        cfg.vpol <= wdata[CFG_VPOL_BIT];
                        cfg.hpol <= wdata[CFG_HPOL_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            A_CTRL: begin
                rdata[CTRL_EN_BIT]  = en_q;
                rdata[CTRL_IMM_BIT] = imm_q;
            end
            A_PIXCNT: rdata = {{PIX_PAD{1'b0}}, pixcnt};
            A_LINE:   rdata = {{LINE_PAD{1'b0}}, line};
            A_HWID:   rdata = {{WID_PAD{1'b0}}, hwid};
            A_VWID:   rdata = {{WID_PAD{1'b0}}, vwid};
            A_CFG: begin
                rdata[CFG_MODE_LO+1:CFG_MODE_LO] = cfg.mode;
                rdata[CFG_VPOL_BIT]              = cfg.vpol;
                rdata[CFG_HPOL_BIT]              = cfg.hpol;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsx_pulse_qual.sv
`timescale 1ns/1ps
module tsx_pulse_qual
    import tsx_pkg::*;
#(
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig,
    input  logic             pol,
    input  logic [WID_W-1:0] width,
    output logic             accept
);
    logic             act;
    logic [WID_W-1:0] need;
    logic [WID_W-1:0] run_q;

    assign act  = level_active(sig, pol);
    assign need = (width == '0) ? WID_W'(1) : width;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!act)
            run_q <= '0;
        else if (run_q != '1)
            run_q <= run_q + 1'b1;
    end

    // Fires once, on the sample where the active run reaches the minimum
    assign accept = act && (({1'b0, run_q} + 1'b1) == {1'b0, need});
endmodule

// File: rtl/tsx_seq.sv
`timescale 1ns/1ps
module tsx_seq
    import tsx_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_imm,
    input  logic              abort,
    input  te_mode_e          mode,
    input  logic [LINE_W-1:0] line,
    input  logic [PIX_W-1:0]  pixcnt,
    input  logic              v_acc,
    input  logic              h_acc,
    input  logic              pix_ack,
    output logic              pix_req,
    output logic              frame_end,
    output logic              frame_done
);
    seq_state_e        st;
    logic [PIX_W-1:0]  rem;
    logic              seen_v;
    logic [LINE_W-1:0] lcnt;
    logic              done_q;
    logic              te_go;
    logic              line_hit;

    assign line_hit = (({1'b0, lcnt} + 1'b1) == {1'b0, line});

    always_comb begin
        case (mode)
            TE_VSYNC: te_go = v_acc;
            TE_LINE:  te_go = (v_acc && (line == '0)) ||
                              (!v_acc && seen_v && h_acc && line_hit);
            default:  te_go = 1'b0;
        endcase
    end

    assign pix_req    = (st == SQ_RUN) && (rem != '0);
    assign frame_end  = (st == SQ_RUN) &&
                        ((rem == '0) || (pix_ack && (rem == PIX_W'(1))));
    assign frame_done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            rem    <= '0;
            seen_v <= 1'b0;
            lcnt   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                st <= SQ_IDLE;
            end else begin
                case (st)
                    SQ_IDLE: begin
                        if (start) begin
                            rem    <= pixcnt;
                            seen_v <= 1'b0;
                            lcnt   <= '0;
                            st     <= start_imm ? SQ_RUN : SQ_WAIT;
                        end
                    end
                    SQ_WAIT: begin
                        if (te_go) begin
                            st <= SQ_RUN;
                        end else if (mode == TE_LINE) begin
                            if (v_acc) begin
                                seen_v <= 1'b1;
                                lcnt   <= '0;
                            end else if (h_acc && seen_v) begin
                                lcnt <= lcnt + 1'b1;
                            end
                        end
                    end
                    SQ_RUN: begin
                        if (frame_end) begin
                            st     <= SQ_IDLE;
                            done_q <= 1'b1;
                        end else if (pix_req && pix_ack) begin
                            rem <= rem - 1'b1;
                        end
                    end
                    default: st <= SQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/tear_sync_xfer.sv
`timescale 1ns/1ps
module tear_sync_xfer
    import tsx_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int WID_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        te_hsync,
    input  logic        te_vsync,
    output logic        pix_req,
    input  logic        pix_ack,
    output logic        frame_done
);
    logic              en_q;
    logic              start, start_imm, abort, frame_end;
    logic [PIX_W-1:0]  pixcnt;
    logic [LINE_W-1:0] line;
    logic [WID_W-1:0]  hwid, vwid;
    te_cfg_t           cfg;

    logic [N_CH-1:0]   ch_sig, ch_pol, ch_acc;
    logic [WID_W-1:0]  ch_wid [N_CH];

    tsx_regs #(.PIX_W(PIX_W), .WID_W(WID_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .frame_end (frame_end),
        .rdata     (reg_rdata),
        .en        (en_q),
        .start     (start),
        .start_imm (start_imm),
        .abort     (abort),
        .pixcnt    (pixcnt),
        .line      (line),
        .hwid      (hwid),
        .vwid      (vwid),
        .cfg       (cfg)
    );

    assign ch_sig[CH_H] = te_hsync;
    assign ch_sig[CH_V] = te_vsync;
    assign ch_pol[CH_H] = cfg.hpol;
    assign ch_pol[CH_V] = cfg.vpol;
    assign ch_wid[CH_H] = hwid;
    assign ch_wid[CH_V] = vwid;

    for (genvar g = 0; g < N_CH; g++) begin : g_qual
        tsx_pulse_qual #(.WID_W(WID_W)) u_qual (
            .clk    (clk),
            .rst    (rst),
            .sig    (ch_sig[g]),
            .pol    (ch_pol[g]),
            .width  (ch_wid[g]),
            .accept (ch_acc[g])
        );
    end

    tsx_seq #(.PIX_W(PIX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_imm  (start_imm),
        .abort      (abort),
        .mode       (cfg.mode),
        .line       (line),
        .pixcnt     (pixcnt),
        .v_acc      (ch_acc[CH_V]),
        .h_acc      (ch_acc[CH_H]),
        .pix_ack    (pix_ack),
        .pix_req    (pix_req),
        .frame_end  (frame_end),
        .frame_done (frame_done)
    );
endmodule

// File: rtl/tear_sync_xfer_chk.sv
`timescale 1ns/1ps
module tear_sync_xfer_chk (
    input logic clk,
    input logic rst,
    input logic reg_wr,
    input logic pix_req,
    input logic pix_ack,
    input logic frame_done,
    input logic en
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!pix_req && !frame_done));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_req && !pix_ack && !reg_wr) |=> pix_req);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R4
    done_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !en);

    // R11
    req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        pix_req |-> en);

    // R4
    done_after_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_done) |-> $past(en));
endmodule

bind tear_sync_xfer tear_sync_xfer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .pix_req    (pix_req),
    .pix_ack    (pix_ack),
    .frame_done (frame_done),
    .en         (en_q)
);

// File: tb/tear_sync_xfer_bench.sv
`timescale 1ns/1ps
module tear_sync_xfer_bench;
    import tsx_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        te_hsync = 1'b0;
    logic        te_vsync = 1'b0;
    logic        pix_ack = 1'b0;
    logic        pix_req, frame_done;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tear_sync_xfer u_tear_sync_xfer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .te_hsync(te_hsync), .te_vsync(te_vsync),
        .pix_req(pix_req), .pix_ack(pix_ack), .frame_done(frame_done)
    );

    // {pixel count, acknowledge every Nth cycle}
    localparam int VN = 6;
    localparam logic [15:0] VEC [VN] = '{16'h0101, 16'h0501, 16'h0402,
                                         16'h0303, 16'h0001, 16'h0704};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic te_pulse(input bit is_v, input bit lvl, input int len);
        @(negedge clk);
        if (is_v) te_vsync = lvl; else te_hsync = lvl;
        repeat (len) @(negedge clk);
        if (is_v) te_vsync = !lvl; else te_hsync = !lvl;
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input int e, output int hs, output int last,
                        output int doneit, output int ndone);
        hs = 0; last = 0; doneit = 0; ndone = 0;
        for (int it = 1; it <= 300; it++) begin
            @(negedge clk);
            if (frame_done) begin
                ndone++;
                if (doneit == 0) doneit = it;
            end
            pix_ack = ((it % e) == 0);
            if (pix_req && pix_ack) begin
                hs++;
                last = it;
            end
            if (doneit != 0 && it > doneit + 3) break;
        end
        pix_ack = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual unfinished expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int hs, last, doneit, ndone, seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 pix_req", pix_req, 0);
        chk("R1 frame_done", frame_done, 0);
        rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
        rd(A_CFG, d);   chk("R1 cfg", d, 32'h0030_0000);

        // Vector walk: immediate transfers, R2 R4 R5
        for (int v = 0; v < VN; v++) begin
            int n, e;
            n = int'(VEC[v][15:8]);
            e = int'(VEC[v][7:0]);
            wr(A_PIXCNT, n);
            wr(A_CTRL, 32'h11);
            xfer(e, hs, last, doneit, ndone);
            chk((n == 0) ? "R5 handshakes" : "R2 handshakes", hs, n);
            chk((n == 0) ? "R5 done timing" : "R4 done timing", doneit, last + 1);
            chk("R4 single pulse", ndone, 1);
            rd(A_CTRL, d); chk("R4 enable cleared", d, 32'h10);
        end

        // R3 hold without acknowledge, then R11 abort
        wr(A_PIXCNT, 2);
        wr(A_CTRL, 32'h11);
        repeat (5) @(negedge clk);
        chk("R3 request held", pix_req, 1);
        chk("R3 no early done", frame_done, 0);
        wr(A_CTRL, 32'h0);
        chk("R11 request dropped", pix_req, 0);
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (frame_done) seen++;
        end
        chk("R11 no done", seen, 0);
        rd(A_CTRL, d); chk("R11 enable off", d, 0);

        // R6 / R7 vsync mode with width 3
        wr(A_VWID, 3);
        wr(A_CFG, 32'h0030_0004);
        wr(A_PIXCNT, 1);
        wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        chk("R6 waits for sync", pix_req, 0);
        te_pulse(1, 1, 2);
        chk("R7 short pulse ignored", pix_req, 0);
        te_pulse(1, 1, 3);
        chk("R6 R7 vsync releases", pix_req, 1);
        xfer(1, hs, last, doneit, ndone);
        chk("R6 one pixel", hs, 1);

        // R6 mode 0 never releases
        wr(A_CFG, 32'h0030_0000);
        wr(A_CTRL, 32'h1);
        te_pulse(1, 1, 4);
        chk("R6 mode off holds", pix_req, 0);
        wr(A_CTRL, 32'h0);

        // R8 active-low vsync
        te_vsync = 1'b1;
        wr(A_CFG, 32'h0020_0004);
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        chk("R8 high level inactive", pix_req, 0);
        te_pulse(1, 0, 3);
        chk("R8 low pulse releases", pix_req, 1);
        xfer(1, hs, last, doneit, ndone);
        chk("R8 transfer done", ndone, 1);
        wr(A_CFG, 32'h0030_0008);
        te_vsync = 1'b0;
        repeat (2) @(negedge clk);

        // R9 line mode, hsync width 0, vsync width 1, line 3
        wr(A_HWID, 0);
        wr(A_VWID, 1);
        wr(A_LINE, 3);
        wr(A_CTRL, 32'h1);
        for (int i = 0; i < 3; i++) te_pulse(0, 1, 1);
        chk("R9 hsync before vsync ignored", pix_req, 0);
        te_pulse(1, 1, 1);
        te_pulse(0, 1, 1);
        te_pulse(0, 1, 1);
        chk("R9 two lines not enough", pix_req, 0);
        te_pulse(0, 1, 1);
        chk("R9 R7 third line releases", pix_req, 1);
        xfer(1, hs, last, doneit, ndone);
        chk("R9 transfer done", ndone, 1);

        // R9 line 0 releases on vsync
        wr(A_LINE, 0);
        wr(A_CTRL, 32'h1);
        te_pulse(1, 1, 1);
        chk("R9 line zero", pix_req, 1);
        xfer(1, hs, last, doneit, ndone);

        // R10 line range
        wr(A_LINE, 3);
        wr(A_LINE, 3000);
        rd(A_LINE, d); chk("R10 over-range ignored", d, 3);
        wr(A_LINE, 2047);
        rd(A_LINE, d); chk("R10 max stored", d, 2047);

        // R12 control write on the final handshake edge
        wr(A_PIXCNT, 1);
        wr(A_CTRL, 32'h11);
        pix_ack = 1'b1; reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h11;
        @(negedge clk);
        pix_ack = 1'b0; reg_wr = 1'b0;
        chk("R12 done pulses", frame_done, 1);
        chk("R12 no new request", pix_req, 0);
        repeat (3) @(negedge clk);
        chk("R12 still idle", pix_req, 0);
        rd(A_CTRL, d); chk("R12 enable cleared", d, 32'h10);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule